// File: doc/BRIEF.md
# Reorder Buffer with Multi-Cycle Squash Walk

This block keeps in-flight instructions in program order in a circular buffer. Dispatch appends an entry at the tail, carrying a sequence number, a PC and a next PC. An execution unit later marks the entry complete by its slot index. Commit retires the oldest entry once it is complete and the retire request is high. The block reports full and empty flags, the number of free slots, and the PC, next PC and sequence number of the oldest and newest entries.

On a misprediction the pipeline issues a squash request that names a sequence number. A walker starts at the newest entry and moves toward the oldest. In each cycle it flags at most a fixed number of entries that are younger than the named one. The walk stops at the first entry that is not younger. The flagged entries are then dropped in one step: the tail pointer and the count move back past them. While the walk runs, a done flag stays low, and both insertion and retirement are held off. A later request that names an older instruction replaces the boundary of the walk in progress; any other request during a walk is dropped.

Top module: `rob_sq`

## Requirements
- R1: While reset is low and in the first cycle after it: `empty`=1, `full`=0, `free_cnt`=DEPTH, `sq_done`=1 and `head_ready`=0.
- R2: `full` is 1 exactly when DEPTH entries are held and `empty` is 1 exactly when none are held. `free_cnt` equals DEPTH minus the held count and changes on the clock edge that accepts an insert or a retire. An insert offered while `full` is 1 is dropped.
- R3: An accepted insert writes its sequence number, PC and next PC into slot `ins_idx`, which is the tail slot counted modulo DEPTH from 0 after reset. After the edge, `tail_seq`/`tail_pc` show that entry. `head_seq`/`head_pc`/`head_npc` show the oldest held entry.
- R4: A pulse on `cmpl_valid` marks slot `cmpl_idx` complete. `head_ready` is 1 when the buffer is not empty, the oldest entry is complete and no walk is in progress.
- R5: When `ret_req` and `head_ready` are both 1 and no squash request is present, the oldest entry is retired on that edge. `commit_valid` is 1 during that cycle for an entry that was not squashed.
- R6: An insert and a retire accepted on the same edge leave the held count, and so `free_cnt`, unchanged, and both take effect.
- R7: A squash request removes exactly the entries whose sequence number is greater (unsigned) than the named one. Older entries and the head stay in place. Once the walk ends, `tail_seq` shows the youngest survivor and `free_cnt` grows by the number removed.
- R8: A walk flags at most SQW entries per cycle. `sq_done` drops on the edge after the request. With N younger entries out of C held, `sq_done` stays low for floor(N/SQW)+1 cycles when N<C, and for max(1, ceil(N/SQW)) cycles when N=C.
- R9: No insert is accepted while `sq_done` is 0 or while `sq_valid` is 1. The tail entry does not change during a walk.
- R10: A squash request that arrives during a walk and names a smaller sequence number moves the walk boundary to that number without restarting the walk from the tail. Any other request during a walk is ignored.
- R11: No retirement takes place while a walk is in progress or in a cycle with `sq_valid` high. `head_ready` is 0 during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_npc | input | PC_W | Next PC of the inserted instruction |
| ins_idx | output | IW | Slot that the next insert will use |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_idx | input | IW | Slot to mark complete |
| ret_req | input | 1 | Retire request from commit |
| head_ready | output | 1 | Oldest entry may retire |
| commit_valid | output | 1 | A non-squashed entry retires this cycle |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Sequence number bounding the squash |
| sq_done | output | 1 | No squash walk in progress |
| full | output | 1 | All slots held |
| empty | output | 1 | No slot held |
| free_cnt | output | CW | Number of free slots |
| head_seq | output | SEQ_W | Sequence number of the oldest entry |
| head_pc | output | PC_W | PC of the oldest entry |
| head_npc | output | PC_W | Next PC of the oldest entry |
| tail_seq | output | SEQ_W | Sequence number of the newest entry |
| tail_pc | output | PC_W | PC of the newest entry |

## Verification
Insert and retire can both be accepted on one edge. The bench offers both together on a buffer with one free slot. It judges the result by an unchanged `free_cnt`, by a head that has advanced and by the new sequence number at the tail. A squash request can also arrive in a cycle where insert and retire are both offered. The bench holds all three high, then checks that `commit_valid` stays low. After the walk it checks that the head and tail sequence numbers show that neither the insert nor the retire took effect.

// File: rtl/rob_sq_pkg.sv
// Shared widths and the entry record of the reorder buffer.
// Assumes sequence numbers increase monotonically and do not wrap while in flight.
package rob_sq_pkg;
    parameter int SEQ_W = 16;
    parameter int PC_W  = 32;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic             ready;
        logic             squashed;
    } rob_ent_t;
endpackage

// File: rtl/rob_sq_store.sv
// Entry storage: writes on insert, sets ready on completion, sets the squash flag
// from the walker mask, and offers head/tail reads plus every sequence number.
// Assumes the caller never completes a slot in the same cycle it is written.
module rob_sq_store
    import rob_sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IW-1:0]                wr_idx,
    input  logic [SEQ_W-1:0]             wr_seq,
    input  logic [PC_W-1:0]              wr_pc,
    input  logic [PC_W-1:0]              wr_npc,
    input  logic                         cmpl_en,
    input  logic [IW-1:0]                cmpl_idx,
    input  logic [DEPTH-1:0]             sq_mark,
    input  logic [IW-1:0]                head_idx,
    input  logic [IW-1:0]                last_idx,
    output rob_ent_t                     head_ent,
    output logic [SEQ_W-1:0]             last_seq,
    output logic [PC_W-1:0]              last_pc,
    output logic [DEPTH-1:0][SEQ_W-1:0]  seq_all
);
    rob_ent_t ent [DEPTH];

    // One register slot per entry, each updated by its own write/complete/mark strobes.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent[g] <= '{seq: wr_seq, pc: wr_pc, npc: wr_npc, ready: 1'b0, squashed: 1'b0};
            end else begin
                if (cmpl_en && cmpl_idx == IW'(g)) ent[g].ready <= 1'b1;
                if (sq_mark[g])                    ent[g].squashed <= 1'b1;
            end
        end
        assign seq_all[g] = ent[g].seq;
    end

    // Read ports for the oldest and newest entries.
    always_comb begin
        head_ent = ent[head_idx];
        last_seq = ent[last_idx].seq;
        last_pc  = ent[last_idx].pc;
    end
endmodule

// File: rtl/rob_sq_walk.sv
// Squash walker: from the newest entry toward the oldest, flags up to SQW younger
// entries per cycle and reports the total removed when it meets an older entry
// or runs out of entries. Assumes no insert or retire happens during a walk.
module rob_sq_walk
    import rob_sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQW   = 2,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic [SEQ_W-1:0]             req_seq,
    input  logic [IW-1:0]                tail,
    input  logic [CW-1:0]                count,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_all,
    output logic [DEPTH-1:0]             mark,
    output logic                         finish,
    output logic [CW-1:0]                reclaim_n,
    output logic                         done
);
    logic             walking;
    logic [IW-1:0]    pos;
    logic [CW-1:0]    left;
    logic [CW-1:0]    total;
    logic [SEQ_W-1:0] bound;
    logic [CW-1:0]    nmark;
    logic             restart;

    assign restart = walking && req && (req_seq < bound);

    // Examine up to SQW entries below the walk position, stopping at the first older one.
    always_comb begin
        logic alive;
        logic [IW-1:0] idx;
        alive = 1'b1;
        nmark = '0;
        mark  = '0;
        for (int i = 0; i < SQW; i++) begin
            idx   = pos - IW'(i);
            alive = alive && (CW'(i) < left) && (seq_all[idx] > bound);
            if (alive && walking && !restart) begin
                mark[idx] = 1'b1;
                nmark     = nmark + 1'b1;
            end
        end
        finish    = walking && !restart && ((nmark < CW'(SQW)) || (nmark == left));
        reclaim_n = total + nmark;
    end

    // Walk state: start on a request, narrow the boundary on an older request, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking <= 1'b0;
            pos     <= '0;
            left    <= '0;
            total   <= '0;
            bound   <= '0;
        end else if (!walking) begin
            if (req) begin
                walking <= 1'b1;
                pos     <= tail - 1'b1;
                left    <= count;
                total   <= '0;
                bound   <= req_seq;
            end
        end else if (restart) begin
            bound <= req_seq;
        end else if (finish) begin
            walking <= 1'b0;
        end else begin
            pos   <= pos - IW'(SQW);
            left  <= left - CW'(SQW);
            total <= total + CW'(SQW);
        end
    end

    assign done = !walking;
endmodule

// File: rtl/rob_sq_ptrs.sv
// Head, tail and occupancy bookkeeping with flag and free-slot derivation.
// Assumes reclaim never coincides with insert or retire.
module rob_sq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_ins,
    input  logic          do_ret,
    input  logic          do_reclaim,
    input  logic [CW-1:0] reclaim_n,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] free_cnt
);
    // Pointer and count updates for insert, retire and squash reclaim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (do_reclaim) begin
            tail  <= tail - IW'(reclaim_n);
            count <= count - reclaim_n;
        end else begin
            if (do_ins) tail <= tail + 1'b1;
            if (do_ret) head <= head + 1'b1;
            case ({do_ins, do_ret})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy flags and free-slot count.
    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        free_cnt = CW'(DEPTH) - count;
    end
endmodule

// File: rtl/rob_sq.sv
// Reorder buffer top: gates insert, retire and squash against each other and
// ties storage, pointers and the squash walker together.
// Assumes DEPTH is a power of two and SQW does not exceed DEPTH.
module rob_sq
    import rob_sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQW   = 2,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    output logic [IW-1:0]    ins_idx,
    input  logic             cmpl_valid,
    input  logic [IW-1:0]    cmpl_idx,
    input  logic             ret_req,
    output logic             head_ready,
    output logic             commit_valid,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             sq_done,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    free_cnt,
    output logic [SEQ_W-1:0] head_seq,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic [SEQ_W-1:0] tail_seq,
    output logic [PC_W-1:0]  tail_pc
);
    logic [IW-1:0]               head, tail;
    logic [CW-1:0]               count;
    logic [CW-1:0]               reclaim_n;
    logic                        do_ins, do_ret, sq_finish;
    logic [DEPTH-1:0]            sq_mark;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_all;
    rob_ent_t                    head_ent;

    // Acceptance of insert and retire against occupancy and squash activity.
    always_comb begin
        do_ins       = ins_valid && !full && sq_done && !sq_valid;
        head_ready   = !empty && head_ent.ready && sq_done;
        do_ret       = ret_req && head_ready && !sq_valid;
        commit_valid = do_ret && !head_ent.squashed;
        ins_idx      = tail;
        head_seq     = head_ent.seq;
        head_pc      = head_ent.pc;
        head_npc     = head_ent.npc;
    end

    rob_sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_ins     (do_ins),
        .do_ret     (do_ret),
        .do_reclaim (sq_finish),
        .reclaim_n  (reclaim_n),
        .head       (head),
        .tail       (tail),
        .count      (count),
        .full       (full),
        .empty      (empty),
        .free_cnt   (free_cnt)
    );

    rob_sq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_ins),
        .wr_idx   (tail),
        .wr_seq   (ins_seq),
        .wr_pc    (ins_pc),
        .wr_npc   (ins_npc),
        .cmpl_en  (cmpl_valid),
        .cmpl_idx (cmpl_idx),
        .sq_mark  (sq_mark),
        .head_idx (head),
        .last_idx (tail - 1'b1),
        .head_ent (head_ent),
        .last_seq (tail_seq),
        .last_pc  (tail_pc),
        .seq_all  (seq_all)
    );

    rob_sq_walk #(.DEPTH(DEPTH), .SQW(SQW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (sq_valid),
        .req_seq   (sq_seq),
        .tail      (tail),
        .count     (count),
        .seq_all   (seq_all),
        .mark      (sq_mark),
        .finish    (sq_finish),
        .reclaim_n (reclaim_n),
        .done      (sq_done)
    );
endmodule

// File: rtl/rob_sq_chk.sv
// Protocol checker for rob_sq, attached by bind; observes ports and the walker mask.
module rob_sq_chk
    import rob_sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQW   = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sq_valid,
    input logic             sq_done,
    input logic             full,
    input logic             empty,
    input logic [CW-1:0]    free_cnt,
    input logic [SEQ_W-1:0] tail_seq,
    input logic             head_ready,
    input logic             ret_req,
    input logic             commit_valid,
    input logic [DEPTH-1:0] mark_vec
);
    assert_full_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_cnt == '0));
    assert_empty_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (free_cnt == CW'(DEPTH)));
    assert_commit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (ret_req && head_ready));
    assert_walk_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_done) |=> !sq_done);
    assert_sq_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark_vec) <= SQW);
    assert_tail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_done && !$past(sq_done)) |-> ($stable(tail_seq) && $stable(free_cnt)));
    assert_no_retire_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done |-> (!head_ready && !commit_valid));
endmodule

bind rob_sq rob_sq_chk #(.DEPTH(DEPTH), .SQW(SQW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sq_valid     (sq_valid),
    .sq_done      (sq_done),
    .full         (full),
    .empty        (empty),
    .free_cnt     (free_cnt),
    .tail_seq     (tail_seq),
    .head_ready   (head_ready),
    .ret_req      (ret_req),
    .commit_valid (commit_valid),
    .mark_vec     (sq_mark)
);

// File: tb/tb_rob_sq.sv
// Directed bench for rob_sq with DEPTH=8, SQW=2; one task per scenario.
module tb_rob_sq;
    localparam int DEPTH = 8;
    localparam int SQW   = 2;
    localparam int IW    = 3;
    localparam int CW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [15:0] ins_seq = '0;
    logic [31:0] ins_pc = '0, ins_npc = '0;
    logic [IW-1:0] ins_idx;
    logic        cmpl_valid = 1'b0;
    logic [IW-1:0] cmpl_idx = '0;
    logic        ret_req = 1'b0;
    logic        head_ready, commit_valid;
    logic        sq_valid = 1'b0;
    logic [15:0] sq_seq = '0;
    logic        sq_done, full, empty;
    logic [CW-1:0] free_cnt;
    logic [15:0] head_seq, tail_seq;
    logic [31:0] head_pc, head_npc, tail_pc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rob_sq #(.DEPTH(DEPTH), .SQW(SQW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_npc(ins_npc),
        .ins_idx(ins_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .ret_req(ret_req), .head_ready(head_ready), .commit_valid(commit_valid),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_done(sq_done),
        .full(full), .empty(empty), .free_cnt(free_cnt),
        .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc),
        .tail_seq(tail_seq), .tail_pc(tail_pc)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(int s);
        ins_valid = 1'b1;
        ins_seq   = 16'(s);
        ins_pc    = 32'h1000 + 32'(4 * s);
        ins_npc   = 32'h1004 + 32'(4 * s);
        step();
        ins_valid = 1'b0;
    endtask

    task automatic complete(int idx);
        cmpl_valid = 1'b1;
        cmpl_idx   = IW'(idx);
        step();
        cmpl_valid = 1'b0;
    endtask

    task automatic wait_walk(output int n);
        n = 0;
        while (!sq_done && n < 40) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset();
        chk("R1 empty", 64'(empty), 1);
        chk("R1 full", 64'(full), 0);
        chk("R1 free", 64'(free_cnt), DEPTH);
        chk("R1 sq_done", 64'(sq_done), 1);
        chk("R1 head_ready", 64'(head_ready), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 ins_idx", 64'(ins_idx), 64'(i));
            put(10 + i);
            chk("R3 tail_seq", 64'(tail_seq), 64'(10 + i));
            chk("R2 free", 64'(free_cnt), 64'(DEPTH - 1 - i));
        end
        chk("R3 tail_pc", 64'(tail_pc), 64'h1000 + 4 * 17);
        chk("R2 full", 64'(full), 1);
        chk("R2 empty", 64'(empty), 0);
        put(99);
        chk("R2 insert when full tail", 64'(tail_seq), 17);
        chk("R2 insert when full free", 64'(free_cnt), 0);
        chk("R3 head_seq", 64'(head_seq), 10);
        chk("R3 head_pc", 64'(head_pc), 64'h1028);
        chk("R3 head_npc", 64'(head_npc), 64'h102c);
    endtask

    task automatic t_retire();
        chk("R4 not ready", 64'(head_ready), 0);
        complete(0);
        chk("R4 ready", 64'(head_ready), 1);
        ret_req = 1'b1;
        #1;
        chk("R5 commit_valid", 64'(commit_valid), 1);
        step();
        ret_req = 1'b0;
        chk("R5 head advanced", 64'(head_seq), 11);
        chk("R5 free", 64'(free_cnt), 1);
        chk("R2 not full", 64'(full), 0);
    endtask

    task automatic t_simul();
        complete(1);
        ret_req = 1'b1;
        put(18);
        ret_req = 1'b0;
        chk("R6 free unchanged", 64'(free_cnt), 1);
        chk("R6 head", 64'(head_seq), 12);
        chk("R6 tail", 64'(tail_seq), 18);
    endtask

    task automatic t_squash();
        int n;
        complete(2);
        sq_valid  = 1'b1;
        sq_seq    = 16'd14;
        ins_valid = 1'b1;
        ins_seq   = 16'd50;
        ret_req   = 1'b1;
        #1;
        chk("R11 no commit with squash", 64'(commit_valid), 0);
        step();
        sq_valid = 1'b0;
        chk("R8 done drops", 64'(sq_done), 0);
        chk("R11 head_ready in walk", 64'(head_ready), 0);
        wait_walk(n);
        ins_valid = 1'b0;
        ret_req   = 1'b0;
        chk("R8 walk cycles partial", 64'(n), 3);
        chk("R7 tail survivor", 64'(tail_seq), 14);
        chk("R7 free after reclaim", 64'(free_cnt), 5);
        chk("R11 head kept", 64'(head_seq), 12);
        chk("R9 tail pc", 64'(tail_pc), 64'h1000 + 4 * 14);
    endtask

    task automatic t_restart();
        int n;
        for (int s = 15; s <= 19; s++) put(s);
        chk("R2 full again", 64'(full), 1);
        sq_valid = 1'b1;
        sq_seq   = 16'd17;
        step();
        sq_seq = 16'd13;
        step();
        sq_seq = 16'd16;
        step();
        sq_valid = 1'b0;
        wait_walk(n);
        chk("R10 tail after restart", 64'(tail_seq), 13);
        chk("R10 free after restart", 64'(free_cnt), 6);
        chk("R10 head", 64'(head_seq), 12);
    endtask

    task automatic t_all();
        int n;
        sq_valid = 1'b1;
        sq_seq   = 16'd0;
        step();
        sq_valid = 1'b0;
        wait_walk(n);
        chk("R8 walk cycles all", 64'(n), 1);
        chk("R7 empty after full squash", 64'(empty), 1);
        chk("R7 free after full squash", 64'(free_cnt), DEPTH);
        put(30);
        chk("R3 reuse head", 64'(head_seq), 30);
        chk("R3 reuse tail", 64'(tail_seq), 30);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_fill();
        t_retire();
        t_simul();
        t_squash();
        t_restart();
        t_all();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule